// File: doc/BRIEF.md
# Ternary CAM with Parallel Clause-Parity Checking

The block is a small ternary content-addressable memory. Each entry is a row of symbols, and each symbol is 0, 1 or don't-care. A search compares a key with every row in one cycle. The match lines then feed a priority encoder, which returns the lowest matching row index. Rows are loaded through a simple write port.

The same match lines also drive an integrity check. A check pass walks the symbol columns and issues two single-column lookups per column: one with key bit 1 and one with key bit 0. All other columns are masked.

Every row owns a small accumulator at the end of its match line. This accumulator sums the symbol values of each clause, either modulo 2 or modulo 3. A clause is an interleaved subset of columns, so neighbouring columns always fall in different clauses. When a clause has been swept, each row whose clause sum is non-zero raises a sticky error flag.

Every row is checked at the same time, so a pass takes time proportional to the row width, not to the number of rows. Searches always take precedence over the check pass, which simply waits.

Top module: `tcam_peds_top`

## Requirements
- R1: Column p of a row occupies bits [2p+1:2p] of the row word, and key bit p is compared with it. A symbol code with bit 1 set (11) is don't-care and matches either key bit. Code 00 matches only key bit 0, and code 01 matches only key bit 1.
- R2: A search request captured at a clock edge produces the result after that edge. res_valid is high for one cycle, res_hit shows whether any row matched, and res_idx gives the lowest matching row index, or 0 when nothing matched. res_valid is low in cycles that follow no request.
- R3: A write places wr_data into row wr_idx at the clock edge. Searches from the next cycle onward see the new contents.
- R4: chk_start while idle starts a pass, and chk_busy is high from the next cycle. A pass with no competing searches keeps chk_busy high for exactly 2*ENT_W cycles. chk_done pulses for exactly one cycle, in the first cycle with chk_busy low.
- R5: Clause c holds every column p with p mod CLAUSES equal to c. Each clause is checked separately, so two corrupted adjacent columns are still detected in modulo-2 mode. Two compensating changes within one clause are not detected.
- R6: With chk_gf3 low, a symbol counts 1 for code 01 and 0 for codes 00 and 11. A row's flag is set when any clause sum is odd.
- R7: With chk_gf3 high, a symbol counts 0 for code 00, 1 for code 01 and 2 for code 11. A row's flag is set when any clause sum modulo 3 is non-zero.
- R8: A search requested during a pass is served in that cycle with a correct result. The pass pauses without losing its place, so its length grows by one cycle per such search and its flags are unchanged.
- R9: Error flags persist after a pass, through searches, until the next accepted chk_start clears them. A chk_start during a pass is ignored.
- R10: After reset, res_valid, chk_busy, chk_done and every error flag are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Row write strobe |
| wr_idx | input | $clog2(ENTRIES) | Row written |
| wr_data | input | 2*ENT_W | Row contents, two bits per column |
| srch_req | input | 1 | Search request, takes precedence over checking |
| srch_key | input | ENT_W | Search key |
| res_valid | output | 1 | Search result valid |
| res_hit | output | 1 | Some row matched |
| res_idx | output | $clog2(ENTRIES) | Lowest matching row |
| chk_start | input | 1 | Begin a check pass |
| chk_gf3 | input | 1 | 1 selects modulo-3 sums, 0 selects modulo-2 |
| chk_busy | output | 1 | Check pass in progress |
| chk_done | output | 1 | One-cycle pulse at the end of a pass |
| err_flags | output | ENTRIES | Sticky per-row clause-parity error |

## Verification
A row accumulator that holds a wrong residue shows up only as a wrong err_flags bit. That bit settles at the last lookup of the affected clause, at most 2*ENT_W cycles after chk_start, so every pass is followed by a comparison of the whole flag vector.

A sequencer that skips or repeats a column changes the length of the chk_busy window. It also produces flags for clauses that were never swept, which is why the bench counts the window to the cycle, both with and without searches that pause the pass.

A faulty encoder or lookup mux is visible on res_idx or res_hit one cycle after the request. Searches are therefore also issued inside a pass, where the lookup mux is shared with the checker.

// File: rtl/tcam_peds_pkg.sv
package tcam_peds_pkg;

    // Symbol coding: 2'b00 -> zero, 2'b01 -> one, bit 1 set -> don't-care.
    typedef enum logic {
        CHK_GF2 = 1'b0,
        CHK_GF3 = 1'b1
    } chk_field_e;

    // One ternary cell compare; an uncared column always matches.
    function automatic logic sym_hit(input logic [1:0] sym, input logic care, input logic kbit);
        return !care || sym[1] || (sym[0] == kbit);
    endfunction

    // Residue add in the selected field; operands already reduced.
    function automatic logic [1:0] acc_add(input logic [1:0] a, input logic [1:0] v,
                                           input chk_field_e f);
        logic [2:0] s;
        s = {1'b0, a} + {1'b0, v};
        if (f == CHK_GF3) begin
            if (s >= 3'd3) s = s - 3'd3;
        end else begin
            s = {2'b00, s[0]};
        end
        return s[1:0];
    endfunction

endpackage

// File: rtl/tcam_peds_array.sv
module tcam_peds_array #(
    parameter int N = 8,
    parameter int W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [$clog2(N)-1:0] wr_idx,
    input  logic [2*W-1:0]       wr_data,
    input  logic [W-1:0]         look_key,
    input  logic [W-1:0]         look_care,
    output logic [N-1:0]         match_o
);
    import tcam_peds_pkg::*;

    typedef struct packed {
        logic [N-1:0][2*W-1:0] mem;
    } arr_s;

    arr_s s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_en) s_d.mem[wr_idx] = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // One match line per row: AND of all per-cell compares.
    logic [N-1:0][W-1:0] cell_ok;

    for (genvar e = 0; e < N; e++) begin : g_row
        for (genvar p = 0; p < W; p++) begin : g_col
            assign cell_ok[e][p] = sym_hit(s_q.mem[e][2*p +: 2], look_care[p], look_key[p]);
        end
        assign match_o[e] = &cell_ok[e];
    end

endmodule

// File: rtl/tcam_peds_prio.sv
module tcam_peds_prio #(
    parameter int N = 8
) (
    input  logic [N-1:0]         match_i,
    output logic                 hit_o,
    output logic [$clog2(N)-1:0] idx_o
);
    localparam int IW = $clog2(N);

    always_comb begin
        hit_o = 1'b0;
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (match_i[i]) begin
                hit_o = 1'b1;
                idx_o = IW'(i);
            end
        end
    end

    logic [N-1:0] below_mask;
    assign below_mask = (N'(1) << idx_o) - N'(1);

    // R2: a reported index is a matching row and no lower row matches.
    always_comb begin
        if (hit_o) begin
            a_r2_lowest_hit: assert (match_i[idx_o] && ((match_i & below_mask) == '0));
        end
    end

endmodule

// File: rtl/tcam_peds_seq.sv
module tcam_peds_seq #(
    parameter int W = 8,
    parameter int C = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start_i,
    input  logic                        gf3_i,
    input  logic                        stall_i,
    output logic                        busy_o,
    output logic                        done_o,
    output logic                        clear_o,
    output tcam_peds_pkg::chk_field_e   field_o,
    output logic                        look_o,
    output logic                        phase_a_o,
    output logic                        clause_end_o,
    output logic [$clog2(W)-1:0]        col_o
);
    import tcam_peds_pkg::*;

    localparam int PW  = $clog2(W);
    localparam int CPS = W / C;
    localparam int CW  = (C > 1) ? $clog2(C) : 1;
    localparam int SW  = (CPS > 1) ? $clog2(CPS) : 1;

    typedef struct packed {
        logic       busy;
        logic       done;
        chk_field_e field;
        logic [CW-1:0] clause;
        logic [SW-1:0] step;
        logic       phase_a;
    } seq_s;

    seq_s s_d, s_q;
    logic look, last_step, last_clause;

    assign look        = s_q.busy && !stall_i;
    assign last_step   = (int'(s_q.step) == CPS - 1);
    assign last_clause = (int'(s_q.clause) == C - 1);

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (!s_q.busy) begin
            if (start_i) begin
                s_d.busy    = 1'b1;
                s_d.field   = gf3_i ? CHK_GF3 : CHK_GF2;
                s_d.clause  = '0;
                s_d.step    = '0;
                s_d.phase_a = 1'b0;
            end
        end else if (look) begin
            if (!s_q.phase_a) begin
                s_d.phase_a = 1'b1;
            end else begin
                s_d.phase_a = 1'b0;
                if (last_step) begin
                    s_d.step = '0;
                    if (last_clause) begin
                        s_d.busy   = 1'b0;
                        s_d.done   = 1'b1;
                        s_d.clause = '0;
                    end else begin
                        s_d.clause = s_q.clause + 1'b1;
                    end
                end else begin
                    s_d.step = s_q.step + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy_o       = s_q.busy;
    assign done_o       = s_q.done;
    assign clear_o      = start_i && !s_q.busy;
    assign field_o      = s_q.field;
    assign look_o       = look;
    assign phase_a_o    = s_q.phase_a;
    assign clause_end_o = look && s_q.phase_a && last_step;
    assign col_o        = PW'(int'(s_q.clause) + int'(s_q.step) * C);

    a_r8_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && stall_i) |=> (s_q.busy && $stable(s_q.clause) &&
                                    $stable(s_q.step) && $stable(s_q.phase_a)));

    a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.done |=> !s_q.done);

    a_r4_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.done |-> (!s_q.busy && $past(s_q.busy)));

    a_r9_field_locked: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.busy |=> $stable(s_q.field));

endmodule

// File: rtl/tcam_peds_acc.sv
module tcam_peds_acc #(
    parameter int N = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clear_i,
    input  logic                      look_i,
    input  logic                      phase_a_i,
    input  logic                      clause_end_i,
    input  tcam_peds_pkg::chk_field_e field_i,
    input  logic [N-1:0]              match_i,
    output logic [N-1:0]              flags_o
);
    import tcam_peds_pkg::*;

    typedef struct packed {
        logic [N-1:0][1:0] acc;
        logic [N-1:0]      zero_hit;
        logic [N-1:0]      flag;
    } acc_s;

    acc_s s_d, s_q;

    always_comb begin
        logic [1:0] v;
        logic [1:0] nsum;
        s_d = s_q;
        for (int e = 0; e < N; e++) begin
            v    = 2'd0;
            nsum = 2'd0;
            if (clear_i) begin
                s_d.acc[e]      = 2'd0;
                s_d.zero_hit[e] = 1'b0;
                s_d.flag[e]     = 1'b0;
            end else if (look_i) begin
                if (!phase_a_i) begin
                    s_d.zero_hit[e] = match_i[e];
                end else begin
                    // one-only -> 1, both -> 2 (don't-care), zero-only -> 0
                    v    = match_i[e] ? (s_q.zero_hit[e] ? 2'd2 : 2'd1) : 2'd0;
                    nsum = acc_add(s_q.acc[e], v, field_i);
                    if (clause_end_i) begin
                        s_d.flag[e] = s_q.flag[e] | (nsum != 2'd0);
                        s_d.acc[e]  = 2'd0;
                    end else begin
                        s_d.acc[e]  = nsum;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign flags_o = s_q.flag;

    for (genvar e = 0; e < N; e++) begin : g_chk
        a_r7_acc_reduced: assert property (@(posedge clk) disable iff (!rst_n)
            s_q.acc[e] != 2'd3);
        a_r6_gf2_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
            (field_i == CHK_GF2) |-> (s_q.acc[e][1] == 1'b0));
    end

    a_r9_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_i |=> ((s_q.flag & $past(s_q.flag)) == $past(s_q.flag)));

endmodule

// File: rtl/tcam_peds_top.sv
module tcam_peds_top #(
    parameter int ENTRIES = 8,
    parameter int ENT_W   = 8,
    parameter int CLAUSES = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [$clog2(ENTRIES)-1:0] wr_idx,
    input  logic [2*ENT_W-1:0]         wr_data,
    input  logic                       srch_req,
    input  logic [ENT_W-1:0]           srch_key,
    output logic                       res_valid,
    output logic                       res_hit,
    output logic [$clog2(ENTRIES)-1:0] res_idx,
    input  logic                       chk_start,
    input  logic                       chk_gf3,
    output logic                       chk_busy,
    output logic                       chk_done,
    output logic [ENTRIES-1:0]         err_flags
);
    import tcam_peds_pkg::*;

    localparam int IW = $clog2(ENTRIES);
    localparam int PW = $clog2(ENT_W);

    typedef struct packed {
        logic          valid;
        logic          hit;
        logic [IW-1:0] idx;
    } res_s;

    res_s r_d, r_q;

    logic [ENTRIES-1:0] match;
    logic [ENT_W-1:0]   look_key, look_care;
    logic               enc_hit;
    logic [IW-1:0]      enc_idx;
    logic               seq_look, seq_phase_a, seq_clause_end, seq_clear;
    chk_field_e         seq_field;
    logic [PW-1:0]      seq_col;

    tcam_peds_seq #(.W(ENT_W), .C(CLAUSES)) u_seq (
        .clk(clk), .rst_n(rst_n), .start_i(chk_start), .gf3_i(chk_gf3),
        .stall_i(srch_req), .busy_o(chk_busy), .done_o(chk_done),
        .clear_o(seq_clear), .field_o(seq_field), .look_o(seq_look),
        .phase_a_o(seq_phase_a), .clause_end_o(seq_clause_end), .col_o(seq_col)
    );

    // Search owns the match lines; otherwise one column is probed.
    always_comb begin
        if (srch_req) begin
            look_key  = srch_key;
            look_care = '1;
        end else begin
            look_key  = seq_phase_a ? '1 : '0;
            look_care = ENT_W'(1) << seq_col;
        end
    end

    tcam_peds_array #(.N(ENTRIES), .W(ENT_W)) u_array (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .look_key(look_key), .look_care(look_care),
        .match_o(match)
    );

    tcam_peds_prio #(.N(ENTRIES)) u_prio (
        .match_i(match), .hit_o(enc_hit), .idx_o(enc_idx)
    );

    tcam_peds_acc #(.N(ENTRIES)) u_acc (
        .clk(clk), .rst_n(rst_n), .clear_i(seq_clear), .look_i(seq_look),
        .phase_a_i(seq_phase_a), .clause_end_i(seq_clause_end),
        .field_i(seq_field), .match_i(match), .flags_o(err_flags)
    );

    always_comb begin
        r_d       = r_q;
        r_d.valid = srch_req;
        if (srch_req) begin
            r_d.hit = enc_hit;
            r_d.idx = enc_idx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign res_valid = r_q.valid;
    assign res_hit   = r_q.hit;
    assign res_idx   = r_q.idx;

    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        srch_req |=> res_valid);

    a_r2_no_stray_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !srch_req |=> !res_valid);

    a_r8_search_first: assert property (@(posedge clk) disable iff (!rst_n)
        srch_req |-> !seq_look);

endmodule

// File: tb/tb_tcam_peds_top.sv
`timescale 1ns/1ps
module tb_tcam_peds_top;
    localparam int N  = 8;
    localparam int W  = 8;
    localparam int C  = 2;
    localparam int IW = $clog2(N);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [IW-1:0] wr_idx = '0;
    logic [2*W-1:0] wr_data = '0;
    logic srch_req = 1'b0;
    logic [W-1:0] srch_key = '0;
    logic res_valid, res_hit;
    logic [IW-1:0] res_idx;
    logic chk_start = 1'b0;
    logic chk_gf3 = 1'b0;
    logic chk_busy, chk_done;
    logic [N-1:0] err_flags;

    always #2 clk = ~clk;

    tcam_peds_top #(.ENTRIES(N), .ENT_W(W), .CLAUSES(C)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .srch_req(srch_req), .srch_key(srch_key), .res_valid(res_valid),
        .res_hit(res_hit), .res_idx(res_idx), .chk_start(chk_start),
        .chk_gf3(chk_gf3), .chk_busy(chk_busy), .chk_done(chk_done),
        .err_flags(err_flags)
    );

    int n_vec = 0;
    int n_bad = 0;
    logic [2*W-1:0] model [N];

    // Search table: key -> {hit, idx} for the fixed row set below.
    localparam logic [7:0] T_KEY [10] = '{8'hA5, 8'h35, 8'h45, 8'h11, 8'h22,
                                          8'h81, 8'hBD, 8'h3C, 8'h7E, 8'h00};
    localparam logic [3:0] T_EXP [10] = '{4'h8, 4'h9, 4'hA, 4'hB, 4'hC,
                                          4'hD, 4'hD, 4'h9, 4'hF, 4'hF};

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [2*W-1:0] mk(input logic [W-1:0] care, input logic [W-1:0] val);
        logic [2*W-1:0] r;
        for (int p = 0; p < W; p++) r[2*p +: 2] = care[p] ? {1'b0, val[p]} : 2'b11;
        return r;
    endfunction

    function automatic int sval(input logic [1:0] code, input bit gf3);
        if (code[1]) return gf3 ? 2 : 0;
        return int'(code[0]);
    endfunction

    function automatic logic [1:0] senc(input int v);
        return (v == 0) ? 2'b00 : (v == 1) ? 2'b01 : 2'b11;
    endfunction

    function automatic logic [N-1:0] exp_flags(input bit gf3);
        logic [N-1:0] f = '0;
        int q = gf3 ? 3 : 2;
        for (int e = 0; e < N; e++)
            for (int c = 0; c < C; c++) begin
                int s = 0;
                for (int p = c; p < W; p += C) s += sval(model[e][2*p +: 2], gf3);
                if (s % q != 0) f[e] = 1'b1;
            end
        return f;
    endfunction

    function automatic logic [3:0] ref_search(input logic [W-1:0] key);
        for (int e = 0; e < N; e++) begin
            bit m = 1'b1;
            for (int p = 0; p < W; p++)
                if (!model[e][2*p+1] && model[e][2*p] != key[p]) m = 1'b0;
            if (m) return {1'b1, 3'(e)};
        end
        return 4'h0;
    endfunction

    task automatic wr(input int idx, input logic [2*W-1:0] d);
        wr_en = 1'b1; wr_idx = IW'(idx); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        model[idx] = d;
    endtask

    task automatic search(input logic [W-1:0] key, output logic [3:0] got);
        srch_req = 1'b1; srch_key = key;
        @(negedge clk);
        srch_req = 1'b0;
        got = {res_hit, 3'(res_idx)};
        check(res_valid === 1'b1, "R2 valid", res_valid, 1);
    endtask

    // Rows with valid check symbols: last C columns balance each clause.
    task automatic load_clean(input bit gf3);
        int q = gf3 ? 3 : 2;
        for (int e = 0; e < N; e++) begin
            logic [2*W-1:0] r;
            for (int p = 0; p < W - C; p++) r[2*p +: 2] = senc($urandom_range(q - 1));
            for (int c = 0; c < C; c++) begin
                int s = 0;
                for (int p = c; p < W - C; p += C) s += sval(r[2*p +: 2], gf3);
                r[2*(W-C+c) +: 2] = senc((q - (s % q)) % q);
            end
            wr(e, r);
        end
    endtask

    task automatic flip(input int e, input int p, input bit gf3);
        logic [2*W-1:0] r = model[e];
        int q = gf3 ? 3 : 2;
        r[2*p +: 2] = senc((sval(r[2*p +: 2], gf3) + 1) % q);
        wr(e, r);
    endtask

    task automatic run_pass(input bit gf3, input int n_srch, input bit poke, output int cyc);
        int guard = 0;
        logic [W-1:0] k;
        chk_gf3 = gf3; chk_start = 1'b1;
        @(negedge clk);
        chk_start = 1'b0;
        cyc = 0;
        while (chk_busy && guard < 4000) begin
            guard++; cyc++;
            k = W'($urandom);
            srch_req = (cyc >= 3 && cyc < 3 + n_srch);
            srch_key = k;
            chk_start = poke && (cyc == 5);
            @(negedge clk);
            if (srch_req) begin
                check(res_valid && {res_hit, 3'(res_idx)} == ref_search(k),
                      "R8 search in pass", {res_hit, 3'(res_idx)}, ref_search(k));
            end
            srch_req = 1'b0; chk_start = 1'b0;
        end
        check(chk_done === 1'b1, "R4 done pulse", chk_done, 1);
        @(negedge clk);
        check(chk_done === 1'b0, "R4 done single", chk_done, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [3:0] got;
        int cyc;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check(res_valid === 1'b0, "R10 res_valid", res_valid, 0);
        check(chk_busy === 1'b0, "R10 chk_busy", chk_busy, 0);
        check(chk_done === 1'b0, "R10 chk_done", chk_done, 0);
        check(err_flags === '0, "R10 flags", err_flags, 0);

        // R1/R2 table walk
        wr(0, mk(8'hFF, 8'hA5)); wr(1, mk(8'hF0, 8'h30)); wr(2, mk(8'h0F, 8'h05));
        wr(3, mk(8'hFF, 8'h11)); wr(4, mk(8'hFF, 8'h22)); wr(5, mk(8'hC3, 8'h81));
        wr(6, mk(8'hFF, 8'h3C)); wr(7, mk(8'h00, 8'h00));
        for (int i = 0; i < 10; i++) begin
            search(T_KEY[i], got);
            check(got == T_EXP[i], "R1 R2 table search", got, T_EXP[i]);
            check(got == ref_search(T_KEY[i]), "R2 reference model", got, ref_search(T_KEY[i]));
        end
        @(negedge clk);
        check(res_valid === 1'b0, "R2 no stray valid", res_valid, 0);

        // R3 write then search; R2 miss gives idx 0
        wr(7, mk(8'hFF, 8'hFF));
        search(8'h00, got);
        check(got == 4'h0, "R3 R2 miss after overwrite", got, 0);
        search(8'hFF, got);
        check(got == 4'hF, "R3 new row visible", got, 4'hF);

        // R6 modulo-2 clean pass, then R5 interleaving corners
        load_clean(1'b0);
        run_pass(1'b0, 0, 1'b0, cyc);
        check(cyc == 2*W, "R4 pass length", cyc, 2*W);
        check(err_flags == '0, "R6 clean gf2", err_flags, 0);
        flip(2, 0, 1'b0); flip(5, W-1, 1'b0);
        flip(1, 3, 1'b0); flip(1, 4, 1'b0);
        flip(6, 2, 1'b0); flip(6, 4, 1'b0);
        run_pass(1'b0, 0, 1'b0, cyc);
        check(err_flags == exp_flags(1'b0), "R6 gf2 flags", err_flags, exp_flags(1'b0));
        check(err_flags[1] == 1'b1, "R5 adjacent pair caught", err_flags[1], 1);
        check(err_flags[6] == 1'b0, "R5 same-clause pair cancels", err_flags[6], 0);

        // R7 modulo-3 pass: clean, then single flips including don't-care values
        load_clean(1'b1);
        run_pass(1'b1, 0, 1'b0, cyc);
        check(err_flags == '0, "R7 clean gf3", err_flags, 0);
        flip(0, 1, 1'b1); flip(3, 6, 1'b1); flip(6, 5, 1'b1);
        run_pass(1'b1, 0, 1'b0, cyc);
        check(err_flags == exp_flags(1'b1), "R7 gf3 flags", err_flags, exp_flags(1'b1));
        check(err_flags == 8'b0100_1001, "R7 exact rows", err_flags, 8'h49);

        // R9 flags persist through searches
        search(8'h5A, got);
        search(8'hC3, got);
        check(err_flags == 8'b0100_1001, "R9 sticky", err_flags, 8'h49);

        // R8 stalled pass with R9 ignored restart
        flip(4, 2, 1'b1);
        run_pass(1'b1, 3, 1'b1, cyc);
        check(cyc == 2*W + 3, "R8 R9 stalled length", cyc, 2*W + 3);
        check(err_flags == exp_flags(1'b1), "R8 flags after stalls", err_flags, exp_flags(1'b1));

        // R9 new pass clears old flags
        load_clean(1'b1);
        run_pass(1'b1, 0, 1'b0, cyc);
        check(err_flags == '0, "R9 cleared by new pass", err_flags, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule